// File: doc/BRIEF.md
# Lowest Set Bit Isolation Unit

This execution unit takes one source operand and returns a value in which only the least significant one bit of that operand remains; every other bit is cleared. Along with that value it reports the arithmetic status flags (zero, sign, carry, overflow, plus auxiliary-carry and parity driven low). The operand is 32 or 64 bits wide. The width follows from the processor mode and a width-select input. Some operations are illegal: those with a nonzero vector-length control bit, and any operation in real or virtual-8086 mode. For these the unit returns an illegal-operation fault and no result or flags.

Operations enter through a valid/ready handshake and leave through a second one. The unit holds one registered output slot, controlled by a two-state machine. `ST_EMPTY` has no pending result. `ST_FULL` holds a result that has not yet been taken. The transitions are:
- load (`ST_EMPTY` to `ST_FULL`) when an input is accepted.
- drain (`ST_FULL` to `ST_EMPTY`) when the output is consumed and no new input arrives.
- stall (`ST_FULL` to `ST_FULL`) while the output waits.
- reload (`ST_FULL` to `ST_FULL`) when the output is consumed and a new input is accepted in the same cycle.

A result appears on the output one clock after its input is accepted.

Top module: `lsb_isolate_unit`

## Requirements
- R1: For a legal operation, the result is the active-size source ANDed with its own two's-complement negation, so at most one bit is set and it is the lowest set bit of the source.
- R2: A legal operation whose active-size source is zero returns an all-zero result with the zero flag set and the carry flag clear.
- R3: For a legal operation, the zero flag is 1 exactly when the result is zero. The carry flag is 1 exactly when the active-size source is nonzero. The sign flag equals result bit 31 for 32-bit size and bit 63 for 64-bit size. The overflow, auxiliary-carry and parity outputs are always 0.
- R4: The mode encoding on `in_mode` is 0 = real, 1 = virtual-8086, 2 = protected, 3 = long. Only in long mode does `in_wide`=1 select 64 bits. Every other case uses 32 bits, ignores the upper 32 source bits, and zero-fills result bits 63..32.
- R5: An operation with `in_vlen`=1 completes with `out_fault`=1.
- R6: An operation in real or virtual-8086 mode completes with `out_fault`=1.
- R7: A faulting operation returns an all-zero result with all flags 0. A legal operation returns `out_fault`=0.
- R8: While `out_valid` is high and `out_ready` is low, the result, flags and fault stay unchanged on the next cycle.
- R9: `in_ready` is high whenever the output slot is empty or is being consumed in the same cycle. An accepted input appears on the output exactly one cycle later, in order.
- R10: While reset is applied and right after it, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input operation present |
| in_ready | output | 1 | Unit can take an input this cycle |
| in_src | input | 64 | Source operand |
| in_mode | input | 2 | Processor mode: 0 real, 1 virtual-8086, 2 protected, 3 long |
| in_wide | input | 1 | Width select, 1 = 64-bit (long mode only) |
| in_vlen | input | 1 | Vector-length control bit, must be 0 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 64 | Isolated lowest set bit |
| out_zf | output | 1 | Zero flag |
| out_sf | output | 1 | Sign flag |
| out_cf | output | 1 | Carry flag |
| out_of | output | 1 | Overflow flag, always 0 |
| out_af | output | 1 | Auxiliary-carry flag, driven 0 |
| out_pf | output | 1 | Parity flag, driven 0 |
| out_fault | output | 1 | Illegal-operation fault |

## Verification
The hardest case to reach is the reload transition. It happens when the consumer takes a result in the same cycle that a new operation arrives, and that case sits right next to a stall. A one-cycle slip in either handshake would repeat or drop an operation. To get there, the bench first runs a directed sequence with continuous flow: zero sources, top-bit sources, a wide request outside long mode, and the three fault causes. It then keeps `in_valid` mostly high while pulling `out_ready` low about one cycle in four. In that phase, stalls, drains and reloads follow one another in every order, mixed with faulting operations. Each cycle, a behavioural queue model in the bench predicts the slot contents and the ready signal.

// File: rtl/lsbi_pkg.sv
`timescale 1ns/1ps
package lsbi_pkg;

    typedef enum logic [1:0] {
        MODE_REAL = 2'd0,
        MODE_V86  = 2'd1,
        MODE_PROT = 2'd2,
        MODE_LONG = 2'd3
    } cpu_mode_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } slot_state_e;

endpackage

// File: rtl/lsbi_decode.sv
`timescale 1ns/1ps
module lsbi_decode
    import lsbi_pkg::*;
(
    input  cpu_mode_e mode,
    input  logic      wide,
    input  logic      vlen,
    output logic      use_wide,
    output logic      fault
);

    // Legality and operand size follow from mode and encoding bits.
    always_comb begin
        fault    = vlen;
        use_wide = 1'b0;
        unique case (mode)
            MODE_REAL: fault    = 1'b1;
            MODE_V86:  fault    = 1'b1;
            MODE_PROT: use_wide = 1'b0;
            MODE_LONG: use_wide = wide;
        endcase
    end

endmodule

// File: rtl/lsbi_core.sv
`timescale 1ns/1ps
module lsbi_core #(
    parameter int unsigned DATA_W = 64
) (
    input  logic [DATA_W-1:0] src,
    input  logic              use_wide,
    output logic [DATA_W-1:0] result,
    output logic              zf,
    output logic              sf,
    output logic              cf
);

    localparam int unsigned HALF_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    logic [DATA_W-1:0] narrow_src;
    logic [DATA_W-1:0] active_src;
    logic [DATA_W-1:0] negated;

    assign narrow_src = {{(DATA_W-HALF_W){1'b0}}, src[HALF_W-1:0]};

    always_comb begin
        active_src = use_wide ? src : narrow_src;
        negated    = (~active_src) + ONE;
        result     = active_src & negated;
        zf         = ~|result;
        cf         = |active_src;
        sf         = use_wide ? result[DATA_W-1] : result[HALF_W-1];
    end

endmodule

// File: rtl/lsb_isolate_unit.sv
`timescale 1ns/1ps
module lsb_isolate_unit
    import lsbi_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_src,
    input  logic [1:0]        in_mode,
    input  logic              in_wide,
    input  logic              in_vlen,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_result,
    output logic              out_zf,
    output logic              out_sf,
    output logic              out_cf,
    output logic              out_of,
    output logic              out_af,
    output logic              out_pf,
    output logic              out_fault
);

    localparam int unsigned HALF_W = DATA_W / 2;

    cpu_mode_e         mode_in;
    logic              use_wide;
    logic              op_fault;
    logic [DATA_W-1:0] core_result;
    logic              core_zf;
    logic              core_sf;
    logic              core_cf;
    logic              accept;
    slot_state_e       state_q;
    slot_state_e       state_d;

    assign mode_in = cpu_mode_e'(in_mode);

    lsbi_decode u_decode (
        .mode     (mode_in),
        .wide     (in_wide),
        .vlen     (in_vlen),
        .use_wide (use_wide),
        .fault    (op_fault)
    );

    lsbi_core #(.DATA_W(DATA_W)) u_core (
        .src      (in_src),
        .use_wide (use_wide),
        .result   (core_result),
        .zf       (core_zf),
        .sf       (core_sf),
        .cf       (core_cf)
    );

    // Handshake-facing outputs of the state machine.
    always_comb begin
        out_valid = (state_q == ST_FULL);
        in_ready  = (state_q == ST_EMPTY) || out_ready;
        accept    = in_valid && in_ready;
        out_of    = 1'b0;
        out_af    = 1'b0;
        out_pf    = 1'b0;
    end

    // Next state: load, drain, stall, reload.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (accept) state_d = ST_FULL;
            ST_FULL:  if (out_ready && !in_valid) state_d = ST_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Output payload register: captured only on an accepted input.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_result <= '0;
            out_zf     <= 1'b0;
            out_sf     <= 1'b0;
            out_cf     <= 1'b0;
            out_fault  <= 1'b0;
        end else if (accept) begin
            if (op_fault) begin
                out_result <= '0;
                out_zf     <= 1'b0;
                out_sf     <= 1'b0;
                out_cf     <= 1'b0;
                out_fault  <= 1'b1;
            end else begin
                out_result <= core_result;
                out_zf     <= core_zf;
                out_sf     <= core_sf;
                out_cf     <= core_cf;
                out_fault  <= 1'b0;
            end
        end
    end

    // ---------------- assertions ----------------
    assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot0(out_result));

    assert_zf_cf_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_fault) |-> (out_zf != out_cf));

    assert_of_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!out_of && !out_af && !out_pf));

    assert_narrow_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (in_mode != 2'd3)) |=> (out_result[DATA_W-1:HALF_W] == '0));

    assert_vlen_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_vlen) |=> (out_valid && out_fault));

    assert_mode_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (in_mode[1] == 1'b0)) |=> (out_valid && out_fault));

    assert_fault_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fault) |-> (out_result == '0 && !out_zf && !out_cf && !out_sf));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_result) &&
                                       $stable(out_fault) && $stable({out_zf, out_sf, out_cf})));

    assert_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |-> in_ready);

endmodule

// File: tb/tb_lsb_isolate_unit.sv
`timescale 1ns/1ps
module tb_lsb_isolate_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_ready, in_wide, in_vlen;
    logic [63:0] in_src;
    logic [1:0]  in_mode;
    logic        out_valid, out_ready;
    logic [63:0] out_result;
    logic        out_zf, out_sf, out_cf, out_of, out_af, out_pf, out_fault;

    always #4 clk = ~clk;

    lsb_isolate_unit #(.DATA_W(64)) dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_src(in_src),
        .in_mode(in_mode), .in_wide(in_wide), .in_vlen(in_vlen),
        .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
        .out_zf(out_zf), .out_sf(out_sf), .out_cf(out_cf), .out_of(out_of),
        .out_af(out_af), .out_pf(out_pf), .out_fault(out_fault)
    );

    int errors = 0;
    int checks = 0;

    typedef struct {
        logic [63:0] res;
        bit zf, sf, cf, fault;
    } exp_t;

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic exp_t model(logic [63:0] src, logic [1:0] mode, bit wide, bit vlen);
        exp_t e;
        int size;
        logic [63:0] s;
        e.res = '0; e.zf = 0; e.sf = 0; e.cf = 0; e.fault = 0;
        if (vlen || mode < 2) begin
            e.fault = 1;
            return e;
        end
        size = (mode == 2'd3 && wide) ? 64 : 32;
        s = (size == 64) ? src : {32'h0, src[31:0]};
        for (int i = 0; i < size; i++) begin
            if (s[i]) begin
                e.res[i] = 1'b1;
                break;
            end
        end
        e.zf = (e.res == 0);
        e.cf = (s != 0);
        e.sf = e.res[size-1];
        return e;
    endfunction

    task automatic directed(int n);
        in_vlen = 0; in_wide = 0; in_mode = 2'd2;
        case (n)
            0:  begin in_src = 64'h0; in_mode = 2'd3; in_wide = 1; end            // R2
            1:  begin in_src = 64'h1; end                                        // R1
            2:  begin in_src = 64'h0000_0000_8000_0000; end                      // R3 sign at bit 31
            3:  begin in_src = 64'hFFFF_0000_0000_0000; in_wide = 1; end         // R4 wide ignored
            4:  begin in_src = 64'hFFFF_0000_0000_0000; in_mode = 2'd3; in_wide = 1; end
            5:  begin in_src = 64'h8000_0000_0000_0000; in_mode = 2'd3; in_wide = 1; end
            6:  begin in_src = 64'h8000_0000_0000_0000; in_mode = 2'd3; end      // R4 narrow in long
            7:  begin in_src = 64'h0000_00F0_0000_0C00; in_mode = 2'd3; end
            8:  begin in_src = 64'h10; in_mode = 2'd3; in_vlen = 1; end          // R5
            9:  begin in_src = 64'h10; in_mode = 2'd0; end                       // R6
            10: begin in_src = 64'h10; in_mode = 2'd1; end                       // R6
            default: begin in_src = 64'hFFFF_FFFF_FFFF_FFFF; in_mode = 2'd3; in_wide = 1; end
        endcase
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    bit          m_valid = 0;
    exp_t        m_exp;
    bit          stalled = 0;
    logic [63:0] last_res;

    initial begin
        rst_n = 0; in_valid = 0; out_ready = 0;
        in_src = '0; in_mode = 2'd2; in_wide = 0; in_vlen = 0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R10", "out_valid in reset", {63'h0, out_valid}, 64'h0);
        rst_n = 1;
        @(negedge clk);
        check(out_valid == 1'b0, "R10", "out_valid after reset", {63'h0, out_valid}, 64'h0);
        check(in_ready == 1'b1, "R9", "in_ready when empty", {63'h0, in_ready}, 64'h1);

        for (int cyc = 0; cyc < 3000; cyc++) begin
            bit fire_out, acc;
            @(negedge clk);
            check(out_valid == m_valid, "R9", "out_valid", {63'h0, out_valid}, {63'h0, m_valid});
            if (m_valid && out_valid) begin
                check(out_result == m_exp.res, "R1/R4", "result", out_result, m_exp.res);
                check(out_zf == m_exp.zf && out_cf == m_exp.cf, "R2/R3", "zf,cf",
                      {62'h0, out_zf, out_cf}, {62'h0, m_exp.zf, m_exp.cf});
                check(out_sf == m_exp.sf, "R3", "sf", {63'h0, out_sf}, {63'h0, m_exp.sf});
                check(!out_of && !out_af && !out_pf, "R3", "of,af,pf",
                      {61'h0, out_of, out_af, out_pf}, 64'h0);
                check(out_fault == m_exp.fault, "R5/R6/R7", "fault",
                      {63'h0, out_fault}, {63'h0, m_exp.fault});
                if (stalled)
                    check(out_result == last_res, "R8", "held result", out_result, last_res);
            end
            check(in_ready == (!m_valid || out_ready), "R9", "in_ready",
                  {63'h0, in_ready}, {63'h0, (!m_valid || out_ready)});

            last_res = out_result;
            if (cyc < 12) begin
                in_valid = 1; out_ready = 1;
                directed(cyc);
            end else begin
                in_valid  = ($urandom % 3) != 0;
                out_ready = ($urandom % 4) != 0;
                in_src    = {$urandom, $urandom} << ($urandom % 64);
                if ($urandom % 8 == 0) in_src = '0;
                in_mode   = 2'($urandom % 4);
                in_wide   = 1'($urandom % 2);
                in_vlen   = ($urandom % 8) == 0;
            end

            fire_out = m_valid && out_ready;
            acc      = in_valid && (!m_valid || out_ready);
            stalled  = m_valid && !out_ready;
            if (fire_out) m_valid = 0;
            if (acc) begin
                m_valid = 1;
                m_exp   = model(in_src, in_mode, in_wide, in_vlen);
            end
        end
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        summary();
        $finish;
    end

endmodule